// File: doc/BRIEF.md
# Latched character input port with service request

This block is a byte-wide input peripheral on a processor bus that is 16 bits wide. An external source such as a keyboard scanner presents one 8-bit ASCII character with a one-cycle strobe. The port latches the character and raises a level service request, which a separate priority encoder samples on its level-2 input. The request stays high until the processor reads the port. That single read returns the character on the low byte of the data bus and withdraws the request.

The port decodes only the most significant address bit. It therefore answers at byte address 0x800000 and at every alias with that bit set. A read is acknowledged one clock after the bus presents select, read and a matching address together. If a second character arrives before the first has been read, the new one replaces the old one and a sticky overrun flag is raised. The next completed read clears that flag.

Top module: `kbd_latch_port`

## Requirements
- R1: A cycle with `src_stb` high loads `src_data` into the held byte, and `irq` is high from the next clock on.
- R2: Once `irq` is high, it stays high on every cycle until a read of the port completes.
- R3: When `bus_sel`, `bus_rd` and `bus_addr[23]` are all high at a clock edge and `bus_ack` is low, `bus_ack` is high for exactly the following cycle. During that cycle `bus_dout[7:0]` carries the held byte and `bus_dout[15:8]` is zero. `irq` is low after the edge that ends the acknowledge cycle, unless R7 applies.
- R4: A bus access with `bus_addr[23]` low, or with `bus_rd` low, gets no acknowledge and leaves `irq` and the held byte unchanged.
- R5: `bus_dout` is all zero on every cycle in which `bus_ack` is low.
- R6: A strobe while `irq` is high, outside an acknowledge cycle, replaces the held byte, keeps `irq` high and sets `overrun` from the next clock on.
- R7: A completed read clears `overrun`. If a strobe falls in the acknowledge cycle itself, the read still returns the old byte, the new byte is held, `irq` stays high and `overrun` is low.
- R8: After reset, `irq`, `overrun` and `bus_ack` are low, and the held byte is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_stb | input | 1 | One-cycle character strobe from the source |
| src_data | input | 8 | ASCII character from the source |
| bus_sel | input | 1 | Bus cycle select |
| bus_rd | input | 1 | High for a read cycle |
| bus_addr | input | 24 | Byte address; only bit 23 is decoded |
| bus_dout | output | 16 | Read data; character on bits 7:0 during the acknowledge cycle |
| bus_ack | output | 1 | Read acknowledge, one cycle long |
| irq | output | 1 | Level service request to priority input 2 |
| overrun | output | 1 | Sticky flag: a character was lost |

## Verification
A strobe shows up as `irq` on the cycle after the strobe edge. For a read, `bus_ack` and the data arrive one cycle after the decode edge, and `irq` falls one cycle after that. The bench drives all inputs on falling edges and samples on the next falling edge, so each result is checked half a cycle after the rising edge that produces it. The driver task queues the byte each read should return. A monitor pops one entry on every acknowledge cycle and compares it with the bus data, so an acknowledge that comes late, comes twice or carries the wrong byte shows up as a miscompare.

// File: rtl/kbd_latch_port.sv
module kbd_latch_port #(
  parameter int CHAR_W = 8,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_stb,
  input  logic [CHAR_W-1:0] src_data,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_dout,
  output logic              bus_ack,
  output logic              irq,
  output logic              overrun
);
  localparam int PAD_W = BUS_W - CHAR_W;

  logic [CHAR_W-1:0] held;
  logic              pending, lost, ack_q;
  logic              hit;

  assign hit = bus_sel & bus_rd & bus_addr[ADDR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= hit & ~ack_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       held <= '0;
    else if (src_stb) held <= src_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pending <= 1'b0;
    else if (src_stb) pending <= 1'b1;
    else if (ack_q)   pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             lost <= 1'b0;
    else if (ack_q)                         lost <= 1'b0;
    else if (src_stb && pending)            lost <= 1'b1;
  end

  assign bus_dout = ack_q ? {{PAD_W{1'b0}}, held} : '0;
  assign bus_ack  = ack_q;
  assign irq      = pending;
  assign overrun  = lost;
endmodule

// File: rtl/kbd_latch_port_chk.sv
module kbd_latch_port_chk #(
  parameter int CHAR_W = 8,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_stb,
  input logic [CHAR_W-1:0] src_data,
  input logic              bus_sel,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_dout,
  input logic              bus_ack,
  input logic              irq,
  input logic              overrun
);
  a_r1_strobe_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    src_stb |=> irq);
  a_r2_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !bus_ack) |=> irq);
  a_r3_ack_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && bus_addr[ADDR_W-1] && !bus_ack) |=> bus_ack);
  a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && !src_stb) |=> !irq);
  a_r4_no_ack_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_rd && bus_addr[ADDR_W-1]) |=> !bus_ack);
  a_r5_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (bus_dout == '0));
  a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (src_stb && irq && !bus_ack) |=> overrun);
  a_r7_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !overrun);
endmodule

bind kbd_latch_port kbd_latch_port_chk #(
  .CHAR_W(CHAR_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_stb(src_stb), .src_data(src_data),
  .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_dout(bus_dout), .bus_ack(bus_ack), .irq(irq), .overrun(overrun)
);

// File: tb/kbd_latch_port_tb.sv
module kbd_latch_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_stb = 1'b0;
  logic [7:0]  src_data = '0;
  logic        bus_sel = 1'b0;
  logic        bus_rd = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_dout;
  logic        bus_ack, irq, overrun;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  kbd_latch_port u_dut (
    .clk(clk), .rst_n(rst_n), .src_stb(src_stb), .src_data(src_data),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_ack(bus_ack), .irq(irq), .overrun(overrun)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // R3 R5 monitor: every ack cycle pops one expected byte
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bus_ack) begin
        if (exp_q.size() == 0) check("R4 unexpected ack", 16'd1, 16'd0);
        else check("R3 read data", bus_dout, {8'h00, exp_q.pop_front()});
      end else begin
        check("R5 dout idle zero", bus_dout, 16'h0000);
      end
    end
  end

  task automatic strobe(input logic [7:0] b);
    @(negedge clk); src_stb = 1'b1; src_data = b;
    @(negedge clk); src_stb = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] exp);
    @(negedge clk); bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 24'h800000;
    exp_q.push_back(exp);
    @(negedge clk); bus_sel = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    check("watchdog", 16'd1, 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 irq reset", {15'd0, irq}, 16'd0);
    check("R8 overrun reset", {15'd0, overrun}, 16'd0);
    check("R8 ack reset", {15'd0, bus_ack}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(8'h00);
    check("R8 held byte zero, no irq", {15'd0, irq}, 16'd0);

    strobe(8'h41);
    check("R1 irq after strobe", {15'd0, irq}, 16'd1);
    repeat (5) @(negedge clk);
    check("R2 irq held", {15'd0, irq}, 16'd1);

    @(negedge clk); bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 24'h400000;
    repeat (2) @(negedge clk);
    check("R4 wrong address no ack", {15'd0, bus_ack}, 16'd0);
    bus_addr = 24'h800000; bus_rd = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 write no ack", {15'd0, bus_ack}, 16'd0);
    bus_sel = 1'b0;
    check("R4 irq unchanged", {15'd0, irq}, 16'd1);

    bus_read(8'h41);
    check("R3 irq cleared", {15'd0, irq}, 16'd0);

    strobe(8'h7a);
    bus_read(8'h7a);
    check("R3 second char cleared", {15'd0, irq}, 16'd0);

    strobe(8'h31);
    check("R6 no overrun single", {15'd0, overrun}, 16'd0);
    strobe(8'h32);
    check("R6 overrun set", {15'd0, overrun}, 16'd1);
    check("R6 irq kept", {15'd0, irq}, 16'd1);
    bus_read(8'h32);
    check("R7 overrun cleared", {15'd0, overrun}, 16'd0);
    check("R6 irq cleared after read", {15'd0, irq}, 16'd0);

    strobe(8'h55);
    @(negedge clk); bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 24'hffffff;
    exp_q.push_back(8'h55);
    @(negedge clk); bus_sel = 1'b0; bus_rd = 1'b0;
    src_stb = 1'b1; src_data = 8'h66;
    @(negedge clk); src_stb = 1'b0;
    check("R7 irq kept on collision", {15'd0, irq}, 16'd1);
    check("R7 overrun low on collision", {15'd0, overrun}, 16'd0);
    bus_read(8'h66);
    check("R7 irq cleared after collision read", {15'd0, irq}, 16'd0);

    repeat (2) @(negedge clk);
    check("R3 queue drained", exp_q.size(), 16'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule